// File: doc/BRIEF.md
# Multiplexed Parallel Bus Initiator

This block is the host-side master of a 16-bit bus on which address and data share the same lines. A requester hands it a 32-bit address, a direction and a word count. The block then runs a fixed sequence on the bus. It presents the upper address half and drops the high-address latch strobe. It presents the lower half and drops the low-address latch strobe. It then runs one timed read or write strobe per 16-bit word. At the end it raises both latch strobes, which frees the target's address logic for the next request.

Strobe timing comes from three 8-bit values: a wait before each strobe falls, the strobe's low width, and the release time after it rises. Two sets of these values are held, one per address domain. A small range table picks the domain from the request address when the request is accepted. Data moves on the rising edge of the read or write strobe. The requester supplies write words through a port and advances them on each word acknowledge. Read words appear on a response port with that same acknowledge, and a one-cycle done pulse closes the transfer. The shared lines are exposed as separate out, enable and in vectors, and the pad ring joins them.

Top module: `pbus_initiator`

## Requirements
- R1: After reset, aleh_n, alel_n, rd_n and wr_n are high, bus_oe is low, req_ready is high, and done and word_ack are low.
- R2: In the first cycle after a request is accepted, bus_out carries address bits 31:16 with bus_oe high and aleh_n still high. In the next cycle aleh_n is low and the same half is still driven.
- R3: In the following cycle bus_out carries address bits 15:0 with alel_n high. In the cycle after that alel_n is low. aleh_n stays low from its fall until the transfer ends.
- R4: The first strobe of a transfer falls after max(LAT,1) cycles counted from the cycle after alel_n falls. Each later strobe falls after the release period plus max(LAT,1) cycles.
- R5: A read or write strobe stays low for exactly max(PW,1) cycles.
- R6: After a strobe rises, all strobes stay high for max(REL,1) cycles before the next latency period or the end of the transfer.
- R7: On a write (req_write=1), only wr_n pulses, and bus_oe is high while it is low. bus_out carries the wr_word value present in the last latency cycle before that strobe.
- R8: On a read (req_write=0), only rd_n pulses, and bus_oe is low from the end of the low-address latch until idle. bus_in is sampled at the clock edge where rd_n rises and shown on rd_data.
- R9: A transfer moves req_words_m1+1 words. word_ack pulses once per word, in the first release cycle after that word's strobe rises, while all strobes are high.
- R10: When the last release period expires, aleh_n and alel_n rise together, req_ready returns high, and done is high for exactly that one cycle.
- R11: Timing values are written with cfg_we. cfg_dom selects the domain, and cfg_field selects the value: 0 is LAT, 1 is PW and 2 is REL. Addresses 0x05000000 to 0x05FFFFFF and 0x08000000 to 0x0FFFFFFF use domain 1. Addresses 0x06000000 to 0x07FFFFFF, and every address outside these ranges, use domain 0.
- R12: A request is accepted only while req_ready is high, and a request made while busy is ignored. The domain timing is captured at acceptance, so a configuration write during a transfer affects only later transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Timing value write enable |
| cfg_dom | input | 1 | Domain of the timing write |
| cfg_field | input | 2 | 0 latency, 1 pulse width, 2 release |
| cfg_wdata | input | 8 | Timing value |
| req_valid | input | 1 | Request strobe, taken only when req_ready |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 32 | Transfer start address |
| req_words_m1 | input | 4 | Word count minus one |
| req_ready | output | 1 | Block idle, request can be taken |
| wr_word | input | 16 | Write word supplied by the requester |
| word_ack | output | 1 | One word finished |
| rd_data | output | 16 | Last read word, valid with word_ack on reads |
| done | output | 1 | Transfer finished pulse |
| bus_out | output | 16 | Value driven onto the shared lines |
| bus_oe | output | 1 | Drive enable for the shared lines |
| bus_in | input | 16 | Value seen on the shared lines |
| aleh_n | output | 1 | High-address latch strobe, active low |
| alel_n | output | 1 | Low-address latch strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The bench runs single-word and multi-word reads and writes in both domains. Each transfer is measured cycle by cycle, so a wrong latency, width or release count shows up as a miscounted phase rather than as a wrong final value. It uses addresses at the edges of the range table, and timing values of zero, which keep the latency, low width and release phases apart from the case of skipping a phase. One transfer is issued with a concurrent request and a concurrent configuration write. A follow-up transfer then tells a value captured at acceptance apart from a live one.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    localparam int TW = 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_HSET, ST_HLAT, ST_LSET, ST_LLAT, ST_WAIT, ST_STRB, ST_RELS
    } pbus_state_e;

    typedef struct packed {
        logic [TW-1:0] lat;
        logic [TW-1:0] pw;
        logic [TW-1:0] rel;
    } pbus_timing_t;
endpackage

// File: rtl/pbus_timing_regs.sv
module pbus_timing_regs
    import pbus_pkg::*;
#(
    parameter int DOM_W = 1,
    parameter logic [TW-1:0] RST_LAT = 8'd3,
    parameter logic [TW-1:0] RST_PW  = 8'd2,
    parameter logic [TW-1:0] RST_REL = 8'd2,
    localparam int NUM_DOM = 1 << DOM_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [DOM_W-1:0]   cfg_dom,
    input  logic [1:0]         cfg_field,
    input  logic [TW-1:0]      cfg_wdata,
    output pbus_timing_t       tim_all [NUM_DOM]
);
    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        pbus_timing_t set_d, set_q;

        always_comb begin
            set_d = set_q;
            if (cfg_we && cfg_dom == DOM_W'(d)) begin
                case (cfg_field)
                    2'd0:    set_d.lat = cfg_wdata;
                    2'd1:    set_d.pw  = cfg_wdata;
                    2'd2:    set_d.rel = cfg_wdata;
                    default: ;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) set_q <= '{lat: RST_LAT, pw: RST_PW, rel: RST_REL};
            else        set_q <= set_d;
        end

        assign tim_all[d] = set_q;

        // R11
        cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_dom == DOM_W'(d) && cfg_field == 2'd1) |=> (set_q.pw == $past(cfg_wdata)));
    end
endmodule

// File: rtl/pbus_domain_sel.sv
module pbus_domain_sel #(
    parameter int AW      = 32,
    parameter int DOM_W   = 1,
    parameter int NUM_RNG = 3,
    parameter logic [NUM_RNG*AW-1:0]    RNG_LO  = '0,
    parameter logic [NUM_RNG*AW-1:0]    RNG_HI  = '0,
    parameter logic [NUM_RNG*DOM_W-1:0] RNG_DOM = '0
) (
    input  logic [AW-1:0]    addr,
    output logic [DOM_W-1:0] dom
);
    logic [NUM_RNG-1:0] hit;

    for (genvar r = 0; r < NUM_RNG; r++) begin : g_rng
        assign hit[r] = (addr >= RNG_LO[r*AW +: AW]) && (addr <= RNG_HI[r*AW +: AW]);
    end

    // lowest-index matching range wins; no match selects domain 0
    always_comb begin
        dom = '0;
        for (int r = NUM_RNG - 1; r >= 0; r--) begin
            if (hit[r]) dom = RNG_DOM[r*DOM_W +: DOM_W];
        end
    end
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
#(
    parameter int BW    = 16,
    parameter int LEN_W = 4,
    localparam int AW   = 2 * BW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [LEN_W-1:0] req_words_m1,
    input  pbus_timing_t     req_tim,
    output logic             req_ready,
    input  logic [BW-1:0]    wr_word,
    output logic             word_ack,
    output logic [BW-1:0]    rd_data,
    output logic             done,
    output logic [BW-1:0]    bus_out,
    output logic             bus_oe,
    input  logic [BW-1:0]    bus_in,
    output logic             aleh_n,
    output logic             alel_n,
    output logic             rd_n,
    output logic             wr_n
);
    typedef struct packed {
        pbus_state_e      st;
        logic             wr;
        logic [AW-1:0]    addr;
        logic [LEN_W-1:0] left;
        pbus_timing_t     tim;
        logic [TW-1:0]    cnt;
        logic [BW-1:0]    data;
        logic             ack;
        logic             done;
    } seq_t;

    seq_t n, q;

    always_comb begin
        n      = q;
        n.ack  = 1'b0;
        n.done = 1'b0;
        n.cnt  = q.cnt + TW'(1);
        unique case (q.st)
            ST_IDLE: if (req_valid) begin
                n.st   = ST_HSET;
                n.wr   = req_write;
                n.addr = req_addr;
                n.left = req_words_m1;
                n.tim  = req_tim;
            end
            ST_HSET: n.st = ST_HLAT;
            ST_HLAT: n.st = ST_LSET;
            ST_LSET: n.st = ST_LLAT;
            ST_LLAT: begin
                n.st  = ST_WAIT;
                n.cnt = TW'(1);
            end
            ST_WAIT: if (q.cnt >= q.tim.lat) begin
                n.st  = ST_STRB;
                n.cnt = TW'(1);
                if (q.wr) n.data = wr_word;
            end
            ST_STRB: if (q.cnt >= q.tim.pw) begin
                n.st  = ST_RELS;
                n.cnt = TW'(1);
                n.ack = 1'b1;
                if (!q.wr) n.data = bus_in;
            end
            ST_RELS: if (q.cnt >= q.tim.rel) begin
                n.cnt = TW'(1);
                if (q.left == '0) begin
                    n.st   = ST_IDLE;
                    n.done = 1'b1;
                end else begin
                    n.left = q.left - LEN_W'(1);
                    n.st   = ST_WAIT;
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    // bus pins decode from the registered state only
    assign req_ready = (q.st == ST_IDLE);
    assign aleh_n    = (q.st == ST_IDLE) || (q.st == ST_HSET);
    assign alel_n    = (q.st inside {ST_IDLE, ST_HSET, ST_HLAT, ST_LSET});
    assign rd_n      = !((q.st == ST_STRB) && !q.wr);
    assign wr_n      = !((q.st == ST_STRB) && q.wr);
    assign bus_oe    = (q.st inside {ST_HSET, ST_HLAT, ST_LSET, ST_LLAT})
                     || (q.wr && (q.st inside {ST_WAIT, ST_STRB, ST_RELS}));
    assign bus_out   = (q.st inside {ST_HSET, ST_HLAT}) ? q.addr[AW-1:BW]
                     : (q.st inside {ST_LSET, ST_LLAT}) ? q.addr[BW-1:0]
                     : q.data;
    assign word_ack  = q.ack;
    assign done      = q.done;
    assign rd_data   = q.data;

    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n));
    // R3
    alel_order_chk: assert property (@(posedge clk) disable iff (!rst_n) !alel_n |-> !aleh_n);
    // R4
    stb_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> (!aleh_n && !alel_n));
    // R8
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !bus_oe);
    // R9
    ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) word_ack |-> (rd_n && wr_n));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (aleh_n && alel_n && req_ready));
    // R10
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R12
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && req_valid) |=> $stable(q.addr));
endmodule

// File: rtl/pbus_initiator.sv
module pbus_initiator
    import pbus_pkg::*;
#(
    parameter int BW      = 16,
    parameter int LEN_W   = 4,
    parameter int DOM_W   = 1,
    parameter int NUM_RNG = 3,
    parameter logic [NUM_RNG*2*BW-1:0] RNG_LO  = {32'h0800_0000, 32'h0600_0000, 32'h0500_0000},
    parameter logic [NUM_RNG*2*BW-1:0] RNG_HI  = {32'h0FFF_FFFF, 32'h07FF_FFFF, 32'h05FF_FFFF},
    parameter logic [NUM_RNG*DOM_W-1:0] RNG_DOM = 3'b101,
    parameter logic [TW-1:0] RST_LAT = 8'd3,
    parameter logic [TW-1:0] RST_PW  = 8'd2,
    parameter logic [TW-1:0] RST_REL = 8'd2,
    localparam int AW      = 2 * BW,
    localparam int NUM_DOM = 1 << DOM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [DOM_W-1:0] cfg_dom,
    input  logic [1:0]       cfg_field,
    input  logic [TW-1:0]    cfg_wdata,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [LEN_W-1:0] req_words_m1,
    output logic             req_ready,
    input  logic [BW-1:0]    wr_word,
    output logic             word_ack,
    output logic [BW-1:0]    rd_data,
    output logic             done,
    output logic [BW-1:0]    bus_out,
    output logic             bus_oe,
    input  logic [BW-1:0]    bus_in,
    output logic             aleh_n,
    output logic             alel_n,
    output logic             rd_n,
    output logic             wr_n
);
    pbus_timing_t     tim_all [NUM_DOM];
    logic [DOM_W-1:0] req_dom;
    pbus_timing_t     req_tim;

    pbus_timing_regs #(
        .DOM_W(DOM_W), .RST_LAT(RST_LAT), .RST_PW(RST_PW), .RST_REL(RST_REL)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dom(cfg_dom),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .tim_all(tim_all)
    );

    pbus_domain_sel #(
        .AW(AW), .DOM_W(DOM_W), .NUM_RNG(NUM_RNG),
        .RNG_LO(RNG_LO), .RNG_HI(RNG_HI), .RNG_DOM(RNG_DOM)
    ) u_dsel (
        .addr(req_addr), .dom(req_dom)
    );

    assign req_tim = tim_all[req_dom];

    pbus_seq #(.BW(BW), .LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_words_m1(req_words_m1), .req_tim(req_tim), .req_ready(req_ready),
        .wr_word(wr_word), .word_ack(word_ack), .rd_data(rd_data), .done(done),
        .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
        .aleh_n(aleh_n), .alel_n(alel_n), .rd_n(rd_n), .wr_n(wr_n)
    );
endmodule

// File: tb/pbus_initiator_tb.sv
`timescale 1ns/1ps
module pbus_initiator_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0;
    logic [0:0]  cfg_dom = 0;
    logic [1:0]  cfg_field = 0;
    logic [7:0]  cfg_wdata = 0;
    logic        req_valid = 0;
    logic        req_write = 0;
    logic [31:0] req_addr = 0;
    logic [3:0]  req_words_m1 = 0;
    logic [15:0] wr_word = 0;
    logic [15:0] bus_in = 0;
    logic        req_ready, word_ack, done, bus_oe, aleh_n, alel_n, rd_n, wr_n;
    logic [15:0] rd_data, bus_out;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pbus_initiator u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dom(cfg_dom),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_words_m1(req_words_m1), .req_ready(req_ready),
        .wr_word(wr_word), .word_ack(word_ack), .rd_data(rd_data), .done(done),
        .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
        .aleh_n(aleh_n), .alel_n(alel_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic cfg(input bit d, input logic [1:0] f, input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1; cfg_dom = d; cfg_field = f; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic ack_check(input bit wr, input int idx);
        chk(word_ack, "R9 word_ack", 32'(word_ack), 1);
        if (!wr) chk(rd_data == 16'(16'h5A00 + idx), "R8 rd_data", 32'(rd_data), 32'(16'h5A00 + idx));
    endtask

    // one full transfer, measured phase by phase at falling edges
    task automatic xfer(input bit wr, input logic [31:0] a, input int nw,
                        input int lat, input int pw, input int rel, input bit poke);
        int hi, lo, n;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_words_m1 = 4'(nw - 1);
        @(negedge clk);
        req_valid = 0;
        chk(!req_ready, "R12 busy", 32'(req_ready), 0);
        chk(aleh_n && bus_oe && bus_out == a[31:16], "R2 high setup", 32'(bus_out), 32'(a[31:16]));
        if (poke) begin
            cfg_we = 1; cfg_dom = 0; cfg_field = 2'd1; cfg_wdata = 8'd9;
            req_valid = 1; req_write = 0; req_addr = 32'h0500_0000;
        end
        @(negedge clk);
        if (poke) begin cfg_we = 0; req_valid = 0; end
        chk(!aleh_n && alel_n && bus_out == a[31:16], "R2 high latch", 32'(bus_out), 32'(a[31:16]));
        @(negedge clk);
        chk(!aleh_n && alel_n && bus_out == a[15:0], "R3 low setup", 32'(bus_out), 32'(a[15:0]));
        @(negedge clk);
        chk(!aleh_n && !alel_n && bus_oe && bus_out == a[15:0], "R3 low latch", 32'(bus_out), 32'(a[15:0]));
        @(negedge clk);
        for (int w = 0; w < nw; w++) begin
            wr_word = 16'(16'hC000 + w);
            bus_in  = 16'(16'h5A00 + w);
            hi = 0;
            while ((wr ? wr_n : rd_n) && hi < 1000) begin
                if (w > 0 && hi == 0) ack_check(wr, w - 1);
                if (!wr && hi == 0) chk(!bus_oe, "R8 bus released", 32'(bus_oe), 0);
                hi++;
                @(negedge clk);
            end
            chk(hi == ((w == 0) ? eff(lat) : eff(rel) + eff(lat)), "R4 R6 high time", hi,
                (w == 0) ? eff(lat) : eff(rel) + eff(lat));
            lo = 0;
            while (!(wr ? wr_n : rd_n) && lo < 1000) begin
                if (lo == 0) begin
                    if (wr) chk(bus_oe && rd_n && bus_out == 16'(16'hC000 + w), "R7 write word",
                                32'(bus_out), 32'(16'hC000 + w));
                    else    chk(!bus_oe && wr_n, "R8 read strobe only", {bus_oe, wr_n}, 1);
                end
                lo++;
                @(negedge clk);
            end
            chk(lo == eff(pw), "R5 low width", lo, eff(pw));
        end
        n = 0;
        while (!done && n < 1000) begin
            if (n == 0) ack_check(wr, nw - 1);
            n++;
            @(negedge clk);
        end
        chk(n == eff(rel), "R6 final release", n, eff(rel));
        chk(aleh_n && alel_n && req_ready, "R10 latch strobes up", {aleh_n, alel_n, req_ready}, 3'b111);
        @(negedge clk);
        chk(!done, "R10 done one cycle", 32'(done), 0);
        if (poke) begin
            for (int k = 0; k < 3; k++) begin
                chk(aleh_n && !bus_oe, "R12 busy request ignored", {aleh_n, bus_oe}, 2'b10);
                @(negedge clk);
            end
        end
    endtask

    task automatic t_reset();
        chk(aleh_n && alel_n && rd_n && wr_n, "R1 strobes high", {aleh_n, alel_n, rd_n, wr_n}, 4'hF);
        chk(!bus_oe && req_ready && !done && !word_ack, "R1 idle", {bus_oe, req_ready, done, word_ack}, 4'b0100);
    endtask

    task automatic t_defaults();
        xfer(0, 32'h1000_1234, 1, 3, 2, 2, 0);   // reset timing values
    endtask

    task automatic t_program();
        cfg(0, 2'd0, 8'd2); cfg(0, 2'd1, 8'd3); cfg(0, 2'd2, 8'd1);   // R11
        cfg(1, 2'd0, 8'd1); cfg(1, 2'd1, 8'd2); cfg(1, 2'd2, 8'd4);
    endtask

    task automatic t_read_burst();  xfer(0, 32'h1000_0000, 3, 2, 3, 1, 0); endtask
    task automatic t_write_burst(); xfer(1, 32'h0500_0040, 2, 1, 2, 4, 0); endtask

    task automatic t_domains();     // R11 table edges
        xfer(1, 32'h0600_0000, 1, 2, 3, 1, 0);
        xfer(0, 32'h0800_0000, 2, 1, 2, 4, 0);
        xfer(0, 32'h05FF_FFFF, 1, 1, 2, 4, 0);
        xfer(0, 32'h04FF_FFFF, 1, 2, 3, 1, 0);
        xfer(1, 32'h0FFF_FFFE, 1, 1, 2, 4, 0);
        xfer(1, 32'h1000_0000, 1, 2, 3, 1, 0);
    endtask

    task automatic t_zero();
        cfg(1, 2'd0, 8'd0); cfg(1, 2'd1, 8'd0); cfg(1, 2'd2, 8'd0);
        xfer(0, 32'h0800_0100, 2, 0, 0, 0, 0);
        xfer(1, 32'h0800_0200, 3, 0, 0, 0, 0);
    endtask

    task automatic t_busy();        // R12 capture at acceptance
        xfer(0, 32'h2000_0000, 2, 2, 3, 1, 1);
        xfer(0, 32'h2000_0010, 1, 2, 9, 1, 0);
    endtask

    task automatic t_long();        // R9 longest burst
        xfer(1, 32'h3000_0000, 16, 2, 9, 1, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_defaults();
        t_program();
        t_read_burst();
        t_write_burst();
        t_domains();
        t_zero();
        t_busy();
        t_long();
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule